// File: doc/BRIEF.md
# Burst Attribute Sweep Sequencer

This block produces the burst length, beat size and transaction ID for each write transaction of a traffic command. Each of the three attributes works in one of two modes. In fixed mode it returns a programmed value. In sweep mode it steps through its legal range, moving one step on every transaction-issue strobe. A load strobe does three things at once: it captures the modes and fixed values of a new command, restarts every sweep at its starting point, and fixes the attributes of that command's first transaction.

The length sweep is bounded by a ceiling that depends on the beat size of the same transaction. This keeps a burst inside a 4 KB address window. The size sweep runs downward from the full bus width to one byte, so the length ceiling rises and falls as the sweep proceeds. The data-bus width, the ID width and the protocol generation (AXI3 or AXI4) are parameters. For AXI3 the length field is 4 bits wide; for AXI4 it is 8 bits wide.

Top module: `burst_attr_sweep`

## Requirements
- R1: While reset is asserted and afterwards until the first load, all three attributes are in fixed mode with the value 0, so `len_o`, `size_o` and `id_o` read 0.
- R2: An attribute in fixed mode outputs the value captured at the last load on every transaction, and issue strobes do not change it.
- R3: In sweep mode the length is 0 for the first transaction after a load. Each issue strobe raises it by one, and it returns to 0 on the issue that follows a transaction whose length equalled the ceiling.
- R4: With PROTO_AXI4 = 0, the length ceiling is 15 for every beat size and the length port is 4 bits wide.
- R5: With PROTO_AXI4 = 1, the length port is 8 bits wide and the length ceiling is min(255, 4096 / 2^size − 1). This gives 255 for size codes 0 to 4, 127 for code 5 (32 bytes), 63 for code 6 (64 bytes) and 31 for code 7 (128 bytes).
- R6: In sweep mode the size code is MAX_SIZE = log2(DATA_W/8) for the first transaction after a load. Each issue strobe lowers it by one, and the issue that follows code 0 sets it back to MAX_SIZE.
- R7: In auto mode the ID is 0 for the first transaction after a load. Each issue strobe raises it by one, and the issue that follows 2^ID_W − 1 sets it back to 0.
- R8: The length ceiling used for a transaction is the one for that transaction's own size. If a length that has just been advanced is above the ceiling for the new size, the length becomes 0 instead.
- R9: A cycle with neither load nor issue leaves all outputs unchanged. A cycle with both load and issue acts as a load alone.
- R10: The outputs show a new command's settings and sweep starting values from the cycle after its load strobe, and each issue strobe takes effect on the outputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Captures a new command's modes and fixed values and restarts the sweeps |
| issue_i | input | 1 | One transaction issued; advances the sweeping attributes |
| len_sweep_i | input | 1 | Length mode: 1 sweep, 0 fixed |
| size_sweep_i | input | 1 | Size mode: 1 sweep, 0 fixed |
| id_auto_i | input | 1 | ID mode: 1 auto-increment, 0 fixed |
| len_fix_i | input | 8 (AXI4) / 4 (AXI3) | Fixed length value |
| size_fix_i | input | 3 | Fixed beat-size code |
| id_fix_i | input | ID_W | Fixed ID value |
| len_o | output | 8 (AXI4) / 4 (AXI3) | Burst length of the current transaction |
| size_o | output | 3 | Beat-size code of the current transaction |
| id_o | output | ID_W | ID of the current transaction |

## Verification
The assertions check on every cycle that:
- a swept length never exceeds the ceiling for the size shown beside it;
- a swept size stays within MAX_SIZE;
- the ID moves by exactly one per issue;
- fixed and idle fields hold their values;
- each sweep restarts at the right value after a load.

Only the bench's scenarios show the full wrap points, because those need hundreds of consecutive issues. These are the length wrapping at 63, 127 or 255, the size returning to MAX_SIZE, and a long length being forced to 0 when the size wraps. The bench compares every output against a model written from the requirements for both an AXI4 and an AXI3 configuration. It also checks the load-and-issue collision.

// File: rtl/bas_pkg.sv
package bas_pkg;
   // log2 of the address window that a burst must not cross
   localparam int unsigned PAGE_LOG2  = 12;
   localparam int unsigned AXI3_LEN_W = 4;
   localparam int unsigned AXI4_LEN_W = 8;
   localparam int unsigned SIZE_W     = 3;

   // Largest legal length code for a given size code
   function automatic logic [7:0] beat_len_cap(input bit axi4, input logic [SIZE_W-1:0] sz);
      int unsigned beats;
      if (!axi4) return 8'd15;
      beats = (32'd1 << PAGE_LOG2) >> sz;
      if (beats > 32'd256) beats = 32'd256;
      return 8'(beats - 32'd1);
   endfunction
endpackage

// File: rtl/bas_len_ceiling.sv
module bas_len_ceiling #(
   parameter bit PROTO_AXI4 = 1'b1,
   parameter int LEN_W      = 8
) (
   input  logic [bas_pkg::SIZE_W-1:0] size_i,
   output logic [LEN_W-1:0]           cap_o
);
   generate
      if (PROTO_AXI4) begin : g_axi4
         localparam int unsigned FIELD_BEATS = 1 << LEN_W;
         always_comb begin
            int unsigned beats;
            beats = (32'd1 << bas_pkg::PAGE_LOG2) >> size_i;
            if (beats > FIELD_BEATS) beats = FIELD_BEATS;
            cap_o = LEN_W'(beats - 32'd1);
         end
      end else begin : g_axi3
         // 16 beats of at most 128 bytes never cross the window
         assign cap_o = '1;
      end
   endgenerate
endmodule

// File: rtl/bas_size_seq.sv
module bas_size_seq #(
   parameter int MAX_SIZE = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       restart_i,
   input  logic                       step_i,
   input  logic                       sweep_i,
   input  logic [bas_pkg::SIZE_W-1:0] fix_i,
   output logic [bas_pkg::SIZE_W-1:0] size_o,
   output logic [bas_pkg::SIZE_W-1:0] size_nxt_o
);
   localparam logic [bas_pkg::SIZE_W-1:0] TOP = bas_pkg::SIZE_W'(MAX_SIZE);

   logic [bas_pkg::SIZE_W-1:0] cnt_q;
   logic [bas_pkg::SIZE_W-1:0] cnt_dec;

   assign cnt_dec = (cnt_q == '0) ? TOP : cnt_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= TOP;
      else if (restart_i)          cnt_q <= TOP;
      else if (step_i && sweep_i)  cnt_q <= cnt_dec;
   end

   assign size_o     = sweep_i ? cnt_q : fix_i;
   // size the next transaction will carry if this cycle advances
   assign size_nxt_o = (sweep_i && step_i) ? cnt_dec : size_o;
endmodule

// File: rtl/bas_len_seq.sv
module bas_len_seq #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             step_i,
   input  logic             sweep_i,
   input  logic [LEN_W-1:0] fix_i,
   input  logic [LEN_W-1:0] cap_cur_i,
   input  logic [LEN_W-1:0] cap_nxt_i,
   output logic [LEN_W-1:0] len_o
);
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] adv;
   logic [LEN_W-1:0] nxt;

   always_comb begin
      adv = (cnt_q >= cap_cur_i) ? '0 : cnt_q + 1'b1;
      nxt = (adv > cap_nxt_i) ? '0 : adv;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (restart_i)          cnt_q <= '0;
      else if (step_i && sweep_i)  cnt_q <= nxt;
   end

   assign len_o = sweep_i ? cnt_q : fix_i;
endmodule

// File: rtl/bas_id_seq.sv
module bas_id_seq #(
   parameter int ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart_i,
   input  logic            step_i,
   input  logic            auto_i,
   input  logic [ID_W-1:0] fix_i,
   output logic [ID_W-1:0] id_o
);
   logic [ID_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (restart_i)         cnt_q <= '0;
      else if (step_i && auto_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign id_o = auto_i ? cnt_q : fix_i;
endmodule

// File: rtl/burst_attr_sweep.sv
module burst_attr_sweep #(
   parameter int DATA_W     = 512,
   parameter int ID_W       = 4,
   parameter bit PROTO_AXI4 = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                load_i,
   input  logic                                issue_i,
   input  logic                                len_sweep_i,
   input  logic                                size_sweep_i,
   input  logic                                id_auto_i,
   input  logic [(PROTO_AXI4 ? 8 : 4)-1:0]     len_fix_i,
   input  logic [2:0]                          size_fix_i,
   input  logic [ID_W-1:0]                     id_fix_i,
   output logic [(PROTO_AXI4 ? 8 : 4)-1:0]     len_o,
   output logic [2:0]                          size_o,
   output logic [ID_W-1:0]                     id_o
);
   localparam int LEN_W    = PROTO_AXI4 ? bas_pkg::AXI4_LEN_W : bas_pkg::AXI3_LEN_W;
   localparam int MAX_SIZE = $clog2(DATA_W / 8);

   generate
      if (DATA_W < 8 || DATA_W > 1024 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_dw
         $error("burst_attr_sweep: DATA_W must be a power of two from 8 to 1024");
      end
      if (ID_W < 1 || ID_W > 16) begin : g_bad_idw
         $error("burst_attr_sweep: ID_W must lie in 1..16");
      end
   endgenerate

   // command configuration, captured on load
   logic                          len_sweep_q, size_sweep_q, id_auto_q;
   logic [LEN_W-1:0]              len_fix_q;
   logic [bas_pkg::SIZE_W-1:0]    size_fix_q;
   logic [ID_W-1:0]               id_fix_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_sweep_q  <= 1'b0;
         size_sweep_q <= 1'b0;
         id_auto_q    <= 1'b0;
         len_fix_q    <= '0;
         size_fix_q   <= '0;
         id_fix_q     <= '0;
      end else if (load_i) begin
         len_sweep_q  <= len_sweep_i;
         size_sweep_q <= size_sweep_i;
         id_auto_q    <= id_auto_i;
         len_fix_q    <= len_fix_i;
         size_fix_q   <= size_fix_i;
         id_fix_q     <= id_fix_i;
      end
   end

   // load wins over a simultaneous issue
   logic adv;
   assign adv = issue_i & ~load_i;

   logic [bas_pkg::SIZE_W-1:0] size_cur, size_nxt;
   logic [LEN_W-1:0]           cap_cur, cap_nxt;

   bas_size_seq #(.MAX_SIZE(MAX_SIZE)) u_size (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (load_i),
      .step_i    (adv),
      .sweep_i   (size_sweep_q),
      .fix_i     (size_fix_q),
      .size_o    (size_cur),
      .size_nxt_o(size_nxt)
   );

   bas_len_ceiling #(.PROTO_AXI4(PROTO_AXI4), .LEN_W(LEN_W)) u_cap_cur (
      .size_i(size_cur),
      .cap_o (cap_cur)
   );

   bas_len_ceiling #(.PROTO_AXI4(PROTO_AXI4), .LEN_W(LEN_W)) u_cap_nxt (
      .size_i(size_nxt),
      .cap_o (cap_nxt)
   );

   bas_len_seq #(.LEN_W(LEN_W)) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (load_i),
      .step_i    (adv),
      .sweep_i   (len_sweep_q),
      .fix_i     (len_fix_q),
      .cap_cur_i (cap_cur),
      .cap_nxt_i (cap_nxt),
      .len_o     (len_o)
   );

   bas_id_seq #(.ID_W(ID_W)) u_id (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (load_i),
      .step_i    (adv),
      .auto_i    (id_auto_q),
      .fix_i     (id_fix_q),
      .id_o      (id_o)
   );

   assign size_o = size_cur;
endmodule

// File: rtl/bas_chk.sv
module bas_chk #(
   parameter int DATA_W     = 512,
   parameter int ID_W       = 4,
   parameter bit PROTO_AXI4 = 1'b1
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            load_i,
   input logic                            issue_i,
   input logic                            len_sweep_i,
   input logic                            size_sweep_i,
   input logic                            id_auto_i,
   input logic                            len_sw,
   input logic                            size_sw,
   input logic                            id_sw,
   input logic [(PROTO_AXI4 ? 8 : 4)-1:0] len_o,
   input logic [2:0]                      size_o,
   input logic [ID_W-1:0]                 id_o
);
   localparam int LEN_W    = PROTO_AXI4 ? 8 : 4;
   localparam int MAX_SIZE = $clog2(DATA_W / 8);

   // R3
   len_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && len_sweep_i) |=> (len_o == '0));

   // R6
   size_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && size_sweep_i) |=> (size_o == 3'(MAX_SIZE)));

   // R7
   id_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && id_auto_i) |=> (id_o == '0));

   // R7
   id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !load_i && id_sw) |=> (id_o == ID_W'($past(id_o) + 1'b1)));

   // R3
   len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !load_i && len_sw && !size_sw &&
       ({{(8-LEN_W){1'b0}}, len_o} < bas_pkg::beat_len_cap(PROTO_AXI4, size_o)))
      |=> (len_o == LEN_W'($past(len_o) + 1'b1)));

   // R5 R8
   len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_sw |-> ({{(8-LEN_W){1'b0}}, len_o} <= bas_pkg::beat_len_cap(PROTO_AXI4, size_o)));

   // R6
   size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      size_sw |-> (size_o <= 3'(MAX_SIZE)));

   // R2
   fixed_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !len_sw) |=> $stable(len_o));

   // R2
   fixed_size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !size_sw) |=> $stable(size_o));

   // R2
   fixed_id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !id_sw) |=> $stable(id_o));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !issue_i) |=> ($stable(len_o) && $stable(size_o) && $stable(id_o)));
endmodule

bind burst_attr_sweep bas_chk #(.DATA_W(DATA_W), .ID_W(ID_W), .PROTO_AXI4(PROTO_AXI4)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .load_i      (load_i),
   .issue_i     (issue_i),
   .len_sweep_i (len_sweep_i),
   .size_sweep_i(size_sweep_i),
   .id_auto_i   (id_auto_i),
   .len_sw      (len_sweep_q),
   .size_sw     (size_sweep_q),
   .id_sw       (id_auto_q),
   .len_o       (len_o),
   .size_o      (size_o),
   .id_o        (id_o)
);

// File: tb/burst_attr_sweep_test.sv
module burst_attr_sweep_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       load = 1'b0, issue = 1'b0;
   logic       ls = 1'b0, ss = 1'b0, ia = 1'b0;
   logic [7:0] lf4 = '0;
   logic [3:0] lf3 = '0;
   logic [2:0] sf = '0;
   logic [3:0] if4 = '0;
   logic [2:0] if3 = '0;

   logic [7:0] len4;  logic [2:0] size4; logic [3:0] id4;
   logic [3:0] len3;  logic [2:0] size3; logic [2:0] id3;

   burst_attr_sweep #(.DATA_W(512), .ID_W(4), .PROTO_AXI4(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .load_i(load), .issue_i(issue),
      .len_sweep_i(ls), .size_sweep_i(ss), .id_auto_i(ia),
      .len_fix_i(lf4), .size_fix_i(sf), .id_fix_i(if4),
      .len_o(len4), .size_o(size4), .id_o(id4));

   burst_attr_sweep #(.DATA_W(64), .ID_W(3), .PROTO_AXI4(1'b0)) uut3 (
      .clk(clk), .rst_n(rst_n), .load_i(load), .issue_i(issue),
      .len_sweep_i(ls), .size_sweep_i(ss), .id_auto_i(ia),
      .len_fix_i(lf3), .size_fix_i(sf), .id_fix_i(if3),
      .len_o(len3), .size_o(size3), .id_o(id3));

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // model state, index 0 = AXI4 unit, 1 = AXI3 unit
   int m_len[2], m_size[2], m_id[2], m_lf[2], m_if[2];
   int m_sf = 0;
   bit m_ls = 0, m_ss = 0, m_ia = 0;
   int max_sz[2] = '{6, 3};
   int id_mod[2] = '{16, 8};

   function automatic int cap_of(int k, int sz);
      if (k == 1) return 15;
      if (sz <= 4) return 255;
      if (sz == 5) return 127;
      if (sz == 6) return 63;
      return 31;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare(string tag);
      chk(tag, "axi4 len",  int'(len4),  m_ls ? m_len[0] : m_lf[0]);
      chk(tag, "axi4 size", int'(size4), m_ss ? m_size[0] : m_sf);
      chk(tag, "axi4 id",   int'(id4),   m_ia ? m_id[0] : m_if[0]);
      chk(tag, "axi3 len",  int'(len3),  m_ls ? m_len[1] : m_lf[1]);
      chk(tag, "axi3 size", int'(size3), m_ss ? m_size[1] : m_sf);
      chk(tag, "axi3 id",   int'(id3),   m_ia ? m_id[1] : m_if[1]);
   endtask

   task automatic update_model();
      if (load) begin
         m_ls = ls; m_ss = ss; m_ia = ia;
         m_lf[0] = lf4; m_lf[1] = lf3; m_sf = sf;
         m_if[0] = if4; m_if[1] = if3;
         for (int k = 0; k < 2; k++) begin
            m_len[k] = 0; m_size[k] = max_sz[k]; m_id[k] = 0;
         end
      end else if (issue) begin
         for (int k = 0; k < 2; k++) begin
            int nsz, ecur, enxt, nl;
            nsz  = m_ss ? ((m_size[k] == 0) ? max_sz[k] : m_size[k] - 1) : m_size[k];
            ecur = m_ss ? m_size[k] : m_sf;
            enxt = m_ss ? nsz : m_sf;
            if (m_ls) begin
               nl = (m_len[k] >= cap_of(k, ecur)) ? 0 : m_len[k] + 1;
               if (nl > cap_of(k, enxt)) nl = 0;
               m_len[k] = nl;
            end
            if (m_ia) m_id[k] = (m_id[k] + 1) % id_mod[k];
            m_size[k] = nsz;
         end
      end
   endtask

   // one clock: inputs already set, sample 1 ns after the edge
   task automatic tick(string tag);
      @(posedge clk);
      #1;
      update_model();
      compare(tag);
   endtask

   task automatic do_load(bit l, bit s, bit i, int lfix, int sfix, int ifix, string tag);
      load = 1'b1; issue = 1'b0;
      ls = l; ss = s; ia = i;
      lf4 = 8'(lfix); lf3 = 4'(lfix); sf = 3'(sfix);
      if4 = 4'(ifix); if3 = 3'(ifix);
      tick(tag);
      load = 1'b0;
   endtask

   task automatic issues(int n, string tag);
      issue = 1'b1;
      for (int j = 0; j < n; j++) tick(tag);
      issue = 1'b0;
   endtask

   initial begin
      for (int k = 0; k < 2; k++) begin
         m_len[k] = 0; m_size[k] = 0; m_id[k] = 0; m_lf[k] = 0; m_if[k] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      // R1 outputs during reset
      compare("R1");
      rst_n = 1'b1;
      issue = 1'b1;
      tick("R1");
      tick("R1");
      issue = 1'b0;

      // all sweeps: length wrap, size wrap, id wrap, clamp on size wrap
      do_load(1, 1, 1, 0, 0, 0, "R10");
      issues(700, "R3 R4 R5 R6 R7 R8");

      // length sweep against fixed sizes
      do_load(1, 0, 1, 0, 5, 0, "R10");
      issues(300, "R3 R5 R4");
      do_load(1, 0, 0, 0, 6, 9, "R10");
      issues(140, "R3 R5 R2");
      do_load(1, 0, 0, 0, 2, 3, "R10");
      issues(520, "R3 R5 R4");

      // fixed mode holds across issues
      do_load(0, 0, 0, 13, 4, 5, "R10");
      issues(25, "R2");

      // idle cycles and load colliding with issue
      do_load(1, 1, 1, 0, 0, 0, "R10");
      issues(9, "R3 R6 R7");
      repeat (5) tick("R9");
      issue = 1'b1; load = 1'b1; ls = 1; ss = 1; ia = 1;
      tick("R9");
      load = 1'b0;
      tick("R9");
      issue = 1'b0;

      // constrained random
      void'($urandom(32'd20240601));
      for (int c = 0; c < 4000; c++) begin
         load  = ($urandom % 48) == 0;
         issue = ($urandom % 3) != 0;
         ls = $urandom; ss = $urandom; ia = $urandom;
         lf4 = 8'($urandom); lf3 = 4'($urandom);
         sf = 3'($urandom % 7);
         if4 = 4'($urandom); if3 = 3'($urandom);
         tick("R2 R3 R5 R6 R7 R8 R9 R10");
      end
      load = 1'b0; issue = 1'b0;

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule